// File: doc/BRIEF.md
# VID-on-the-fly reference stepper

This block sits in front of a voltage regulator's reference DAC. It follows a 5-bit voltage-identification (VID) code and produces the reference setting the regulator should regulate to. The setting is given both as a DAC code and in millivolts. The VID inputs are looked at only when a switching-cycle strobe marks the start of a new period. A changed code must read the same at two consecutive strobes before it becomes the target. After that, the reference walks toward the target one code (25 mV) at a time, with one step every two switching periods. The walk never passes the target.

A retarget that arrives while the reference is still walking restarts validation with the newest code. Stepping then continues from wherever the reference currently is, so the output never jumps. The one exception comes right after reset: the first strobe loads the reference straight to the sampled code, because there is no earlier output to protect.

Top module: `vid_ref_stepper`

## Requirements
- R1: While reset is held, and until the first strobe after reset, ref_code_o is 0, ref_mv_o is 1550 and busy_o is low.
- R2: The first strobe after reset loads ref_code_o directly to the sampled vid_i. busy_o stays low, and there is no stepping.
- R3: vid_i is sampled only on clocks where cyc_start_i is high. ref_code_o and busy_o can change only on the clock edge that follows such a strobe, and they stay stable between strobes.
- R4: A code that differs from the accepted target becomes the new target only if the same value is sampled at two consecutive strobes. busy_o rises at the second of those strobes.
- R5: If the code reverts to the accepted target before that second strobe, it is not accepted. If it changes to a third value, validation restarts with that newest value.
- R6: Once a target is accepted while idle, ref_code_o moves by exactly one code every second strobe. The first step comes two strobes after acceptance, so strobe j (with j=1 the accepting strobe) shows floor((j-1)/2) steps.
- R7: Stepping works both upward and downward in code value. The reference never goes past the target, and busy_o is high exactly while ref_code_o differs from the accepted target.
- R8: ref_mv_o equals 1550 − 25 × ref_code_o, so code 0 gives 1550 and code 10 gives 1300.
- R9: Accepting a new target during a walk does not reset the reference or the step cadence. The walk turns toward the new target from the present value, one code per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching period |
| vid_i | input | 5 | Requested VID code |
| ref_code_o | output | 5 | Present reference as a DAC code |
| ref_mv_o | output | 12 | Present reference in millivolts |
| busy_o | output | 1 | Reference differs from the accepted target |

## Verification
The bench sweeps every code as a target, walking up from code 0 and back down again. It then runs a pseudo-random chain of transitions and checks the reference after every strobe against an arithmetic step count. A design that accepted codes after one sample would show busy_o a strobe early. A design that restarted its step timer on acceptance would slip the cadence when a walk is retargeted. Other tests cover a one-period glitch that reverts, a code that changes again before validation, and a reversal in the middle of a walk. A design that jumped, overshot, or validated the wrong candidate would leave the reference at a wrong intermediate value, or would step when no step was due.

// File: rtl/vid_ref_pkg.sv
package vid_ref_pkg;
   // Direction of the code-to-millivolt mapping
   typedef enum logic [0:0] {
      MAP_DESCEND = 1'b0,   // larger code -> lower voltage
      MAP_ASCEND  = 1'b1    // larger code -> higher voltage
   } map_dir_e;
endpackage

// File: rtl/vid_code_filter.sv
module vid_code_filter #(
   parameter int VID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic [VID_W-1:0] vid_i,
   output logic [VID_W-1:0] acc_o,
   output logic             load_o,
   output logic             pend_o
);
   logic             primed_q;
   logic             pend_q;
   logic [VID_W-1:0] cand_q;
   logic [VID_W-1:0] acc_q;

   assign load_o = strobe_i & ~primed_q;
   assign acc_o  = acc_q;
   assign pend_o = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         pend_q   <= 1'b0;
         cand_q   <= '0;
         acc_q    <= '0;
      end else if (strobe_i) begin
         if (!primed_q) begin
            primed_q <= 1'b1;
            acc_q    <= vid_i;
            pend_q   <= 1'b0;
         end else if (pend_q) begin
            if (vid_i == cand_q) begin
               acc_q  <= cand_q;
               pend_q <= 1'b0;
            end else if (vid_i == acc_q) begin
               pend_q <= 1'b0;
            end else begin
               cand_q <= vid_i;
            end
         end else if (vid_i != acc_q) begin
            cand_q <= vid_i;
            pend_q <= 1'b1;
         end
      end
   end

   // R3
   acc_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe_i) |-> $stable(acc_q))
      else $error("accepted code moved without a strobe");

   // R4
   acc_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(primed_q) && (acc_q != $past(acc_q))) |-> ($past(pend_q) && (acc_q == $past(vid_i))))
      else $error("code accepted without a validated candidate");
endmodule

// File: rtl/vid_ref_slew.sv
module vid_ref_slew #(
   parameter int VID_W       = 5,
   parameter int STEP_PERIOD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic             load_i,
   input  logic [VID_W-1:0] load_code_i,
   input  logic [VID_W-1:0] tgt_i,
   output logic [VID_W-1:0] ref_o,
   output logic             busy_o
);
   localparam int CNT_W = (STEP_PERIOD > 1) ? $clog2(STEP_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_PERIOD - 1);

   logic [VID_W-1:0] ref_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_tgt;

   assign at_tgt = (ref_q == tgt_i);
   assign ref_o  = ref_q;
   assign busy_o = ~at_tgt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         ref_q <= load_code_i;
         cnt_q <= '0;
      end else if (strobe_i) begin
         if (at_tgt) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ref_q <= (ref_q < tgt_i) ? ref_q + 1'b1 : ref_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R3
   ref_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe_i) |-> $stable(ref_q))
      else $error("reference moved without a strobe");

   // R6
   one_code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_i) |-> ((ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1)
                          || (ref_q + 1'b1 == $past(ref_q))))
      else $error("reference moved more than one code");

   // R7
   step_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_i) && (ref_q != $past(ref_q))) |-> ($past(ref_q) != $past(tgt_i)))
      else $error("reference stepped while on target");
endmodule

// File: rtl/vid_ref_map.sv
module vid_ref_map
   import vid_ref_pkg::*;
#(
   parameter int       VID_W   = 5,
   parameter int       MV_W    = 12,
   parameter int       TOP_MV  = 1550,
   parameter int       STEP_MV = 25,
   parameter map_dir_e DIR     = MAP_DESCEND
) (
   input  logic [VID_W-1:0] code_i,
   output logic [MV_W-1:0]  mv_o
);
   localparam int MAX_CODE = (1 << VID_W) - 1;

   generate
      if (DIR == MAP_DESCEND) begin : g_desc
         assign mv_o = MV_W'(TOP_MV - STEP_MV * int'(code_i));
      end else begin : g_asc
         assign mv_o = MV_W'(TOP_MV - STEP_MV * (MAX_CODE - int'(code_i)));
      end
   endgenerate
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
   import vid_ref_pkg::*;
#(
   parameter int       VID_W       = 5,
   parameter int       MV_W        = 12,
   parameter int       TOP_MV      = 1550,
   parameter int       STEP_MV     = 25,
   parameter int       STEP_PERIOD = 2,
   parameter map_dir_e DIR         = MAP_DESCEND
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_start_i,
   input  logic [4:0]       vid_i,
   output logic [4:0]       ref_code_o,
   output logic [11:0]      ref_mv_o,
   output logic             busy_o
);
   localparam int MAX_CODE = (1 << VID_W) - 1;

   initial begin
      width_fit_chk: assert (VID_W == 5 && MV_W == 12)
         else $error("port widths are fixed at 5 and 12");
      period_chk: assert (STEP_PERIOD >= 1)
         else $error("STEP_PERIOD must be at least 1");
      range_chk: assert (TOP_MV >= STEP_MV * MAX_CODE && TOP_MV < (1 << MV_W))
         else $error("millivolt range does not fit");
   end

   logic [VID_W-1:0] acc_code;
   logic [VID_W-1:0] ref_code;
   logic             load;
   logic             pend;

   vid_code_filter #(.VID_W(VID_W)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (cyc_start_i),
      .vid_i    (vid_i),
      .acc_o    (acc_code),
      .load_o   (load),
      .pend_o   (pend)
   );

   vid_ref_slew #(.VID_W(VID_W), .STEP_PERIOD(STEP_PERIOD)) u_slew (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_i    (cyc_start_i),
      .load_i      (load),
      .load_code_i (vid_i),
      .tgt_i       (acc_code),
      .ref_o       (ref_code),
      .busy_o      (busy_o)
   );

   vid_ref_map #(
      .VID_W(VID_W), .MV_W(MV_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV), .DIR(DIR)
   ) u_map (
      .code_i (ref_code),
      .mv_o   (ref_mv_o)
   );

   assign ref_code_o = ref_code;

   // R2
   load_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (!busy_o && !pend))
      else $error("initial load left the stepper busy");
endmodule

// File: tb/vid_ref_stepper_tb.sv
module vid_ref_stepper_tb;
   localparam int CLK_P = 10;
   localparam int GAP   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start_i = 1'b0;
   logic [4:0]  vid_i = '0;
   logic [4:0]  ref_code_o;
   logic [11:0] ref_mv_o;
   logic        busy_o;

   int n_chk = 0;
   int n_fail = 0;
   int cur = 0;
   bit done = 0;
   int lcg = 12345;

   always #(CLK_P/2) clk = ~clk;

   vid_ref_stepper u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .vid_i(vid_i),
      .ref_code_o(ref_code_o), .ref_mv_o(ref_mv_o), .busy_o(busy_o)
   );

   task automatic check(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_ref(input int exp_code, input int exp_busy, input string req);
      check(int'(ref_code_o), exp_code, req);
      check(int'(busy_o), exp_busy, req);
      check(int'(ref_mv_o), 1550 - 25 * exp_code, {req, "/R8"});
   endtask

   // One strobe, then GAP idle clocks; outputs must hold across the gap (R3)
   task automatic do_strobe();
      int held;
      @(negedge clk) cyc_start_i = 1'b1;
      @(negedge clk) cyc_start_i = 1'b0;
      held = int'(ref_code_o);
      repeat (GAP) @(negedge clk);
      check(int'(ref_code_o), held, "R3 stable between strobes");
   endtask

   // Uninterrupted walk from cur to 'to', checked after every strobe (R4 R6 R7)
   task automatic run_move(input int to);
      int d, dir, steps, exp;
      d   = (to > cur) ? to - cur : cur - to;
      dir = (to > cur) ? 1 : -1;
      vid_i = 5'(to);
      for (int j = 0; j <= 2 * d + 2; j++) begin
         do_strobe();
         steps = (j == 0) ? 0 : (j - 1) / 2;
         if (steps > d) steps = d;
         exp = cur + dir * steps;
         check_ref(exp, (j >= 1 && exp != to) ? 1 : 0, "R6 R7 walk");
         if (j == 1) check(int'(busy_o), (d > 0) ? 1 : 0, "R4 busy on second strobe");
      end
      cur = to;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_ref(0, 0, "R1 in reset");
      rst_n = 1'b1;
      vid_i = 5'd10;
      repeat (3) @(negedge clk);
      check_ref(0, 0, "R1 before first strobe");
      do_strobe();
      check_ref(10, 0, "R2 direct load");
      check(int'(ref_mv_o), 1300, "R8 code 10");
      cur = 10;
      do_strobe();
      check_ref(10, 0, "R2 no stepping after load");

      run_move(0);
      check(int'(ref_mv_o), 1550, "R8 code 0");

      // Glitch that reverts before validation (R5)
      vid_i = 5'd20; do_strobe();
      check_ref(0, 0, "R5 pending not accepted");
      vid_i = 5'd0;  do_strobe();
      do_strobe(); do_strobe();
      check_ref(0, 0, "R5 revert ignored");

      // Code changes again before validation (R5)
      vid_i = 5'd9;  do_strobe();
      check_ref(0, 0, "R5 first candidate");
      vid_i = 5'd12; do_strobe();
      check_ref(0, 0, "R5 restart with newest");
      do_strobe();
      check_ref(0, 1, "R5 newest accepted");
      do_strobe();
      check_ref(0, 1, "R6 no step yet");
      do_strobe();
      check_ref(1, 1, "R6 first step toward newest");
      for (int k = 0; k < 30; k++) do_strobe();
      check_ref(12, 0, "R5 settled on newest");
      cur = 12;
      run_move(0);

      // Reversal mid-walk (R9)
      vid_i = 5'd20;
      for (int j = 0; j <= 7; j++) do_strobe();
      check_ref(3, 1, "R9 three steps up");
      vid_i = 5'd1;
      do_strobe();
      check_ref(3, 1, "R9 retarget pending");
      do_strobe();
      check_ref(4, 1, "R9 cadence kept on accept");
      do_strobe();
      check_ref(4, 1, "R9 turning");
      do_strobe();
      check_ref(3, 1, "R9 walking down");
      for (int k = 0; k < 4; k++) do_strobe();
      check_ref(1, 0, "R9 R7 landed no overshoot");
      for (int k = 0; k < 4; k++) do_strobe();
      check_ref(1, 0, "R7 holds at target");
      cur = 1;

      // Sweep every code up from 0 and back (R6 R7)
      run_move(0);
      for (int b = 1; b < 32; b++) begin
         run_move(b);
         run_move(0);
      end

      // Pseudo-random transitions
      for (int k = 0; k < 30; k++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         run_move((lcg >> 8) % 32);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule